// File: doc/BRIEF.md
# PHY Management Serial Controller

This block lets software read and write the registers of an external Ethernet PHY over the two-wire management bus. It has one clock line and one bidirectional data line. Software sees two 32-bit registers, selected by a single select input. One is the command register. It holds the PHY address, the PHY register number, a direction flag and a busy flag. The other is the data register. It holds the value to write, or the value returned by a read.

A single write to the command register launches the complete serial frame. To write a PHY register, software first loads the value into the data register and then writes the command register with the direction flag set. To read a PHY register, software writes the command register with the direction flag clear. It then polls busy, and once busy is clear it collects the result from the data register. The management clock is made from the system clock by a parameterised divider. The clock only runs while a frame is in progress.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The command register (select 0) reads back as: busy in bit 0, direction in bit 1 (1 = write, 0 = read), the PHY register number in bits 10:6 and the PHY address in bits 15:11. All other bits read as zero.
- R2: A write to the command register while the block is idle starts a frame. Busy reads as 1 from the next clock cycle.
- R3: Busy stays set for exactly 128 management-clock half periods, that is 128*DIV_HALF system clocks, and then clears.
- R4: A write frame has 64 bits, sent MSB first. The bits are 32 ones, start code 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then the 16 data bits. The output enable is high for all 64 bits.
- R5: A read frame carries opcode 10. The output enable is high for the first 46 bits and low for the last 18 bits, which are the turnaround and data bits.
- R6: During a read, the data input is sampled on each rising management-clock edge of the last 16 bits, MSB first. When busy clears, the 16 bits appear in bits 15:0 of the data register.
- R7: The management clock idles low. While a frame runs, each high phase and each low phase lasts DIV_HALF system clocks, and the clock produces exactly 64 rising edges per frame.
- R8: A write to the command register while busy is set is ignored. The command fields, the frame in progress and the number of frames are all unchanged.
- R9: The data register (select 1) stores bits 15:0 of a write and reads back with bits 31:16 as zero. A write frame leaves it unchanged.
- R10: After reset, both registers read as zero, and the management clock and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions check properties that must hold on every cycle:
- Busy rises only after a command write.
- Busy falls only after the last bit.
- A command write made while busy leaves the fields untouched.
- The clock toggles only when the divider wraps, and it is low whenever the block is idle.
- The two clock strobes never fire together.

The bench scenarios cover what a cycle-local property cannot show:
- The complete 64-bit frame content and the enable pattern, captured on the clock's rising edges.
- The read value taken from a modelled PHY.
- The exact frame duration.
- The absence of a second frame after an ignored command.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;
  localparam int TA_IDX     = 46;  // first turnaround bit position
  localparam int DATA_IDX   = 48;  // first data bit position
  localparam int CMD_BUSY   = 0;
  localparam int CMD_WR     = 1;
  localparam int CMD_REG_LO = 6;
  localparam int CMD_PHY_LO = 11;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wdata;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    return {32'hFFFF_FFFF, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regn,
            (c.wr ? 2'b10 : 2'b11), (c.wr ? c.wdata : 16'hFFFF)};
  endfunction
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mdc_clk_div.sv
module mdc_clk_div #(
  parameter int DIV_HALF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  always_comb begin
    tick  = run && (cnt_q == CNT_LAST);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;

  // R7: the clock may only change right after the divider wraps
  a_r7_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q != $past(mdc_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_data
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_IDX);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_IDX);

  logic                  busy_q, busy_d;
  logic                  wr_q, wr_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [15:0]           rx_q, rx_d;
  logic                  last_fall;

  always_comb begin
    busy_d    = busy_q;
    wr_d      = wr_q;
    idx_d     = idx_q;
    sh_d      = sh_q;
    rx_d      = rx_q;
    last_fall = busy_q && fall_stb && (idx_q == IDX_LAST);
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        wr_d   = cmd.wr;
        idx_d  = '0;
        sh_d   = build_frame(cmd);
        rx_d   = '0;
      end
    end else begin
      if (rise_stb && !wr_q && (idx_q >= IDX_DATA))
        rx_d = {rx_q[14:0], mdio_i};
      if (fall_stb) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      wr_q   <= wr_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy_q && (wr_q || (idx_q < IDX_TA));
  assign rd_done = last_fall && !wr_q;
  assign rd_data = rx_q;

  // R3: a frame only ends after its last bit has been clocked out
  a_r3_end_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(idx_q) == IDX_LAST));
  // R5: the output enable is never active while a read is in its data phase
  a_r5_read_data_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wr_q && rise_stb && (idx_q >= IDX_DATA)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        rst_n_s;
  logic        busy, rise_stb, fall_stb, rd_done;
  logic [15:0] rd_data;
  logic        cmd_req, start;
  mdio_cmd_t   cmd;

  logic        wr_q, wr_d;
  logic [4:0]  phy_q, phy_d;
  logic [4:0]  regn_q, regn_d;
  logic [15:0] data_q, data_d;

  mdio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  mdc_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_n_s), .run(busy),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb));

  always_comb begin
    cmd_req = reg_wr && (reg_sel == 1'b0);
    start   = cmd_req && !busy;
    wr_d    = wr_q;
    phy_d   = phy_q;
    regn_d  = regn_q;
    data_d  = data_q;
    if (start) begin
      wr_d   = reg_wdata[CMD_WR];
      regn_d = reg_wdata[CMD_REG_LO +: 5];
      phy_d  = reg_wdata[CMD_PHY_LO +: 5];
    end
    if (reg_wr && reg_sel) data_d = reg_wdata[15:0];
    if (rd_done)           data_d = rd_data;
    cmd.wr    = reg_wdata[CMD_WR];
    cmd.regn  = reg_wdata[CMD_REG_LO +: 5];
    cmd.phy   = reg_wdata[CMD_PHY_LO +: 5];
    cmd.wdata = data_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q   <= 1'b0;
      phy_q  <= '0;
      regn_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_d;
      phy_q  <= phy_d;
      regn_q <= regn_d;
      data_q <= data_d;
    end
  end

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(start), .cmd(cmd),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_data(rd_data));

  always_comb begin
    if (reg_sel == 1'b0)
      reg_rdata = {16'h0000, phy_q, regn_q, 4'b0000, wr_q, busy};
    else
      reg_rdata = {16'h0000, data_q};
  end

  // R2: busy rises only after a command-register write
  a_r2_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |-> $past(cmd_req));
  // R8: a command write during busy leaves the fields untouched
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_req && busy) |=> ($stable(phy_q) && $stable(regn_q) && $stable(wr_q)));
  // R7: the clock idles low
  a_r7_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !mdc);
  // R7: rising and falling strobes are exclusive
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({rise_stb, fall_stb}));
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  localparam int HALF = 2;
  localparam int NVEC = 4;
  // {wr, phy, reg, data}: data is the write value or the PHY's read response
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1, 5'h01, 5'h00, 16'hA5C3},
    {1'b0, 5'h1F, 5'h02, 16'h1234},
    {1'b1, 5'h10, 5'h1F, 16'h8001},
    {1'b0, 5'h00, 5'h11, 16'hC001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  int          rises = 0;
  int          base = 0;
  logic [15:0] phy_resp = '0;

  mdio_mgmt_ctrl #(.DIV_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  always @(posedge mdc) begin
    cap_o  <= {cap_o[62:0], mdio_o};
    cap_oe <= {cap_oe[62:0], mdio_oe};
    rises  <= rises + 1;
  end

  // PHY model: drives the response data bits after falling clock edges
  always @(negedge mdc) begin
    automatic int nxt = rises - base;
    if (nxt >= 48 && nxt < 64) mdio_i <= phy_resp[63 - nxt];
    else                       mdio_i <= 1'b1;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cmd_word(logic wr, logic [4:0] phy, logic [4:0] rg);
    return {16'h0000, phy, rg, 4'b0000, wr, 1'b0};
  endfunction

  function automatic logic [63:0] exp_frame(logic wr, logic [4:0] phy, logic [4:0] rg,
                                            logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
  endfunction

  task automatic wait_idle(output int n);
    logic [31:0] r;
    n = 0;
    reg_read(1'b0, r);
    while (r[0] && n < 20000) begin
      n++;
      @(negedge clk);
      reg_read(1'b0, r);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    reg_read(1'b0, r); chk("R10 cmd reg", 64'(r), 64'h0);
    reg_read(1'b1, r); chk("R10 data reg", 64'(r), 64'h0);
    chk("R10 mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      automatic logic        wr  = VEC[i][26];
      automatic logic [4:0]  phy = VEC[i][25:21];
      automatic logic [4:0]  rg  = VEC[i][20:16];
      automatic logic [15:0] d   = VEC[i][15:0];
      reg_write(1'b1, wr ? {16'hFFFF, d} : 32'hFFFF_5555);
      reg_read(1'b1, r);
      chk("R9 data upper zero", 64'(r), wr ? 64'(d) : 64'h5555);
      phy_resp = d;
      base = rises;
      r0 = rises;
      reg_write(1'b0, cmd_word(wr, phy, rg) | 32'hFFFF_003C);
      reg_read(1'b0, r);
      chk("R1 R2 cmd readback busy", 64'(r), 64'(cmd_word(wr, phy, rg) | 32'h1));
      wait_idle(n);
      chk("R3 busy duration", 64'(n), 64'(128 * HALF));
      chk("R7 rising edges", 64'(rises - r0), 64'd64);
      if (wr) begin
        chk("R4 write frame", cap_o, exp_frame(1'b1, phy, rg, d));
        chk("R4 write oe", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_read(1'b1, r);
        chk("R9 data kept after write", 64'(r), 64'(d));
      end else begin
        chk("R5 read header", 64'(cap_o[63:18]), 64'(exp_frame(1'b0, phy, rg, 16'h0) >> 18));
        chk("R5 read oe", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
        reg_read(1'b1, r);
        chk("R6 read result", 64'(r), 64'(d));
      end
      reg_read(1'b0, r);
      chk("R1 cmd readback idle", 64'(r), 64'(cmd_word(wr, phy, rg)));
    end

    // R8 / R7: command during busy ignored; clock phase length
    phy_resp = 16'h3C5A;
    base = rises;
    r0 = rises;
    reg_write(1'b0, cmd_word(1'b0, 5'h03, 5'h04));
    @(posedge mdc);
    @(negedge clk);
    n = 0;
    while (mdc && n < 100) begin n++; @(negedge clk); end
    chk("R7 high phase", 64'(n), 64'(HALF));
    n = 0;
    while (!mdc && n < 100) begin n++; @(negedge clk); end
    chk("R7 low phase", 64'(n), 64'(HALF));
    reg_write(1'b0, cmd_word(1'b1, 5'h07, 5'h09));
    reg_read(1'b0, r);
    chk("R8 fields kept while busy", 64'(r), 64'(cmd_word(1'b0, 5'h03, 5'h04) | 32'h1));
    wait_idle(n);
    chk("R8 single frame", 64'(rises - r0), 64'd64);
    chk("R8 original frame opcode", 64'(cap_o[63:18]),
        64'(exp_frame(1'b0, 5'h03, 5'h04, 16'h0) >> 18));
    reg_read(1'b1, r);
    chk("R6 read result after ignored cmd", 64'(r), 64'h3C5A);
    r0 = rises;
    repeat (40) @(negedge clk);
    reg_read(1'b0, r);
    chk("R8 no second frame", {31'h0, r[0], 32'(rises - r0)}, 64'h0);
    chk("R7 idle low", {63'h0, mdc}, 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule